// File: doc/BRIEF.md
# Two-Level Address Translation Cache

This block caches virtual-to-translated address mappings in two levels. A small direct-mapped first level answers most lookups one cycle after the request. Behind it sits a four-way set-associative second level. Both levels are indexed by the same virtual page-number bits and tagged with the virtual address with its 4 KiB page offset removed. A lookup that misses the first level searches the second level in the next cycle. A hit there refreshes that set's two-bit-per-way age values.

When both levels miss, the block raises a refill request. It then waits for the page description on a fill port, and the requester outside supplies that description from its own page walk. Each entry carries flags. Bit 0 of the flags marks a memory page. A memory page yields the stored offset plus the virtual address and is promoted into the first level. Any other page is a device page, which yields the virtual address minus the stored device base and leaves the first level unchanged. A single invalidate input empties both levels in one cycle.

Top module: `xlat_tlb2`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `resp_valid` and `refill_req` are 0 and `req_ready` is 1. Every entry of both levels starts invalid, so the first lookup of any page raises a refill.
- R2: The first-level index is va[12+IDX_W-1:12] and the tag is va[31:12]. A request accepted while that entry is valid with a matching tag gives `resp_valid`=1 and `resp_l1`=1 in the next cycle. The response carries `resp_addr` = stored offset + va and the stored flags and physical tag.
- R3: On a first-level miss, the second level is searched in the set selected by the same index bits. A hit there responds two cycles after acceptance with `resp_l1`=0 and does not raise `refill_req`.
- R4: A second-level hit, or a refill, in way h sets the age of way h to 3 and the age of its pair partner (h XOR 1) to 2. The two ways of the other pair keep only bit 0 of their age.
- R5: The refill victim is the lowest-numbered invalid way of the set. If every way is valid, it is the lowest-numbered way with age 0. Otherwise it is the way with the smallest age, taking the lowest index among ties.
- R6: On a miss in both levels, `refill_req` rises two cycles after acceptance with `refill_va` = va. It stays high until `fill_valid` is sampled. The fill is then written into the victim way, and the response follows in the next cycle.
- R7: A response from the second level or from a fill whose flags bit 0 is 1 gives `resp_dev`=0 and `resp_addr` = offset + va. It also overwrites the first-level entry, so the next access to that page hits in the first level.
- R8: An entry whose flags bit 0 is 0 gives `resp_dev`=1 and `resp_addr` = va − device base. The first level is not written, so the page previously held at that index still hits there.
- R9: `req_ready` is 0 while a second-level search or a refill is in progress, and while `inval_all` is high. A request presented while `req_ready` is 0 is ignored.
- R10: One cycle of `inval_all` clears the valid bits of both levels. The next access to any previously cached page raises a refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inval_all | input | 1 | Clear all entries of both levels |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | VA_W | Virtual address to translate |
| req_ready | output | 1 | Block can accept a request this cycle |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_addr | output | VA_W | Translated (or device-relative) address |
| resp_flags | output | FLAG_W | Flags of the entry used |
| resp_ptag | output | PTAG_W | Physical tag of the entry used |
| resp_dev | output | 1 | Entry was a device page |
| resp_l1 | output | 1 | Response came from the first level |
| refill_req | output | 1 | Both levels missed; page description needed |
| refill_va | output | VA_W | Virtual address of the missing page |
| fill_valid | input | 1 | Fill data present |
| fill_flags | input | FLAG_W | Flags of the filled page (bit 0 = memory) |
| fill_offset | input | VA_W | Offset added to va for memory pages |
| fill_devbase | input | VA_W | Base subtracted from va for device pages |
| fill_ptag | input | PTAG_W | Physical tag of the filled page |

## Verification
The assertions check the following on every cycle:
- A first-level hit yields a response in the next cycle.
- At most one second-level way matches.
- A refill request holds until fill data arrives and keeps the block not ready.
- Memory-page responses from the second level follow a first-level write, and device responses never do.
- An invalidate leaves no valid entry in either level.

The age update and victim choice (R4, R5) show only through the bench's scenarios. There, a reference model predicts for every access whether it hits the first level, hits the second level or needs a refill, and which page a later miss evicts. The address arithmetic, the preservation of the first level under device fills, and the ignoring of requests during invalidate are also shown only by those scenarios.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef logic [WAYS-1:0][1:0] age_set_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROBE,
    ST_FILL
  } xlat_st_t;

  // Age refresh for a touch of way hw: hw -> 3, partner -> 2, other pair keeps bit 0.
  function automatic age_set_t age_touch(input age_set_t cur, input logic [WAY_W-1:0] hw);
    age_set_t nxt;
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == hw)
        nxt[w] = 2'd3;
      else if (WAY_W'(w) == {hw[1], ~hw[0]})
        nxt[w] = 2'd2;
      else
        nxt[w] = {1'b0, cur[w][0]};
    end
    return nxt;
  endfunction

  // Victim: lowest invalid way, else lowest way with the smallest age.
  function automatic logic [WAY_W-1:0] pick_victim(input logic [WAYS-1:0] vld,
                                                   input age_set_t cur);
    logic             found;
    logic [WAY_W-1:0] v;
    logic [1:0]       best;
    found = 1'b0;
    v     = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !vld[w]) begin
        found = 1'b1;
        v     = WAY_W'(w);
      end
    end
    if (!found) begin
      best = cur[0];
      v    = '0;
      for (int w = 1; w < WAYS; w++) begin
        if (cur[w] < best) begin
          best = cur[w];
          v    = WAY_W'(w);
        end
      end
    end
    return v;
  endfunction

endpackage

// File: rtl/xlat_l1_dm.sv
module xlat_l1_dm #(
  parameter int VA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int IDX_W  = 4,
  parameter int FLAG_W = 4,
  parameter int PTAG_W = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inval,
  input  logic [IDX_W-1:0]       rd_idx,
  input  logic [VA_W-PAGE_W-1:0] rd_tag,
  output logic                   hit,
  output logic [FLAG_W-1:0]      rd_flags,
  output logic [VA_W-1:0]        rd_offs,
  output logic [PTAG_W-1:0]      rd_ptag,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [VA_W-PAGE_W-1:0] wr_tag,
  input  logic [FLAG_W-1:0]      wr_flags,
  input  logic [VA_W-1:0]        wr_offs,
  input  logic [PTAG_W-1:0]      wr_ptag,
  output logic                   any_valid
);
  localparam int TAG_W = VA_W - PAGE_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [FLAG_W-1:0] flg_q [DEPTH];
  logic [VA_W-1:0]   off_q [DEPTH];
  logic [PTAG_W-1:0] ptg_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || inval)
      vld_q <= '0;
    else if (wr_en)
      vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      flg_q[wr_idx] <= wr_flags;
      off_q[wr_idx] <= wr_offs;
      ptg_q[wr_idx] <= wr_ptag;
    end
  end

  assign hit       = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_flags  = flg_q[rd_idx];
  assign rd_offs   = off_q[rd_idx];
  assign rd_ptag   = ptg_q[rd_idx];
  assign any_valid = |vld_q;

endmodule

// File: rtl/xlat_l2_sa.sv
module xlat_l2_sa
  import xlat_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int IDX_W  = 4,
  parameter int FLAG_W = 4,
  parameter int PTAG_W = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inval,
  input  logic [IDX_W-1:0]       set_idx,
  input  logic [VA_W-PAGE_W-1:0] rd_tag,
  output logic [WAYS-1:0]        hit_vec,
  output logic                   hit,
  output logic [WAY_W-1:0]       hit_way,
  output logic [FLAG_W-1:0]      hit_flags,
  output logic [VA_W-1:0]        hit_offs,
  output logic [VA_W-1:0]        hit_base,
  output logic [PTAG_W-1:0]      hit_ptag,
  output logic [WAY_W-1:0]       victim,
  input  logic                   age_we,
  input  logic [WAY_W-1:0]       age_way,
  input  logic                   fill_we,
  input  logic [WAY_W-1:0]       fill_way,
  input  logic [FLAG_W-1:0]      fill_flags,
  input  logic [VA_W-1:0]        fill_offs,
  input  logic [VA_W-1:0]        fill_base,
  input  logic [PTAG_W-1:0]      fill_ptag,
  output logic                   any_valid
);
  localparam int TAG_W = VA_W - PAGE_W;
  localparam int SETS  = 1 << IDX_W;

  logic [WAYS-1:0]   way_vld;
  logic [WAYS-1:0]   way_any;
  logic [FLAG_W-1:0] flg_w [WAYS];
  logic [VA_W-1:0]   off_w [WAYS];
  logic [VA_W-1:0]   bas_w [WAYS];
  logic [PTAG_W-1:0] ptg_w [WAYS];
  age_set_t          age_q [SETS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]   vld_q;
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [FLAG_W-1:0] flg_q [SETS];
    logic [VA_W-1:0]   off_q [SETS];
    logic [VA_W-1:0]   bas_q [SETS];
    logic [PTAG_W-1:0] ptg_q [SETS];
    logic              wr_here;

    assign wr_here = fill_we && (fill_way == WAY_W'(w));

    always_ff @(posedge clk) begin
      if (rst || inval)
        vld_q <= '0;
      else if (wr_here)
        vld_q[set_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr_here) begin
        tag_q[set_idx] <= rd_tag;
        flg_q[set_idx] <= fill_flags;
        off_q[set_idx] <= fill_offs;
        bas_q[set_idx] <= fill_base;
        ptg_q[set_idx] <= fill_ptag;
      end
    end

    assign way_vld[w] = vld_q[set_idx];
    assign hit_vec[w] = vld_q[set_idx] && (tag_q[set_idx] == rd_tag);
    assign flg_w[w]   = flg_q[set_idx];
    assign off_w[w]   = off_q[set_idx];
    assign bas_w[w]   = bas_q[set_idx];
    assign ptg_w[w]   = ptg_q[set_idx];
    assign way_any[w] = |vld_q;
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign hit       = |hit_vec;
  assign hit_flags = flg_w[hit_way];
  assign hit_offs  = off_w[hit_way];
  assign hit_base  = bas_w[hit_way];
  assign hit_ptag  = ptg_w[hit_way];
  assign victim    = pick_victim(way_vld, age_q[set_idx]);
  assign any_valid = |way_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) age_q[s] <= '0;
    end else if (age_we) begin
      age_q[set_idx] <= age_touch(age_q[set_idx], age_way);
    end
  end

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int FLAG_W = 4,
  parameter int PTAG_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inval_all,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  output logic              req_ready,
  output logic [VA_W-1:0]   cap_va,
  input  logic              l1_hit,
  input  logic [FLAG_W-1:0] l1_flags,
  input  logic [VA_W-1:0]   l1_offs,
  input  logic [PTAG_W-1:0] l1_ptag,
  output logic              l1_we,
  output logic [FLAG_W-1:0] sel_flags,
  output logic [VA_W-1:0]   sel_offs,
  output logic [PTAG_W-1:0] sel_ptag,
  input  logic              l2_hit,
  input  logic [WAY_W-1:0]  l2_way,
  input  logic [FLAG_W-1:0] l2_flags,
  input  logic [VA_W-1:0]   l2_offs,
  input  logic [VA_W-1:0]   l2_base,
  input  logic [PTAG_W-1:0] l2_ptag,
  input  logic [WAY_W-1:0]  l2_victim,
  output logic              age_we,
  output logic [WAY_W-1:0]  age_way,
  output logic              fill_we,
  output logic [WAY_W-1:0]  fill_way,
  input  logic              fill_valid,
  input  logic [FLAG_W-1:0] fill_flags,
  input  logic [VA_W-1:0]   fill_offs,
  input  logic [VA_W-1:0]   fill_base,
  input  logic [PTAG_W-1:0] fill_ptag,
  output logic              resp_valid,
  output logic [VA_W-1:0]   resp_addr,
  output logic [FLAG_W-1:0] resp_flags,
  output logic [PTAG_W-1:0] resp_ptag,
  output logic              resp_dev,
  output logic              resp_l1,
  output logic              refill_req
);
  xlat_st_t         st_q;
  logic [VA_W-1:0]  va_q;
  logic [WAY_W-1:0] vic_q;
  logic [VA_W-1:0]  sel_base;
  logic [VA_W-1:0]  sel_addr;
  logic             accept;

  assign req_ready = (st_q == ST_IDLE) && !inval_all;
  assign accept    = req_valid && req_ready;
  assign cap_va    = va_q;
  assign fill_way  = vic_q;

  always_comb begin
    sel_flags = l2_flags;
    sel_offs  = l2_offs;
    sel_base  = l2_base;
    sel_ptag  = l2_ptag;
    age_way   = l2_way;
    age_we    = 1'b0;
    fill_we   = 1'b0;
    l1_we     = 1'b0;
    if (st_q == ST_FILL) begin
      sel_flags = fill_flags;
      sel_offs  = fill_offs;
      sel_base  = fill_base;
      sel_ptag  = fill_ptag;
      age_way   = vic_q;
    end
    case (st_q)
      ST_PROBE: begin
        if (l2_hit) begin
          age_we = 1'b1;
          l1_we  = l2_flags[0];
        end
      end
      ST_FILL: begin
        if (fill_valid) begin
          fill_we = 1'b1;
          age_we  = 1'b1;
          l1_we   = fill_flags[0];
        end
      end
      default: ;
    endcase
  end

  assign sel_addr = sel_flags[0] ? (sel_offs + va_q) : (va_q - sel_base);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      va_q       <= '0;
      vic_q      <= '0;
      resp_valid <= 1'b0;
      resp_addr  <= '0;
      resp_flags <= '0;
      resp_ptag  <= '0;
      resp_dev   <= 1'b0;
      resp_l1    <= 1'b0;
      refill_req <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (l1_hit) begin
              resp_valid <= 1'b1;
              resp_addr  <= l1_offs + req_va;
              resp_flags <= l1_flags;
              resp_ptag  <= l1_ptag;
              resp_dev   <= 1'b0;
              resp_l1    <= 1'b1;
            end else begin
              va_q <= req_va;
              st_q <= ST_PROBE;
            end
          end
        end
        ST_PROBE: begin
          if (l2_hit) begin
            resp_valid <= 1'b1;
            resp_addr  <= sel_addr;
            resp_flags <= sel_flags;
            resp_ptag  <= sel_ptag;
            resp_dev   <= !sel_flags[0];
            resp_l1    <= 1'b0;
            st_q       <= ST_IDLE;
          end else begin
            vic_q      <= l2_victim;
            refill_req <= 1'b1;
            st_q       <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (fill_valid) begin
            resp_valid <= 1'b1;
            resp_addr  <= sel_addr;
            resp_flags <= sel_flags;
            resp_ptag  <= sel_ptag;
            resp_dev   <= !sel_flags[0];
            resp_l1    <= 1'b0;
            refill_req <= 1'b0;
            st_q       <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xlat_tlb2.sv
module xlat_tlb2
  import xlat_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int IDX_W  = 4,
  parameter int FLAG_W = 4,
  parameter int PTAG_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inval_all,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [VA_W-1:0]   resp_addr,
  output logic [FLAG_W-1:0] resp_flags,
  output logic [PTAG_W-1:0] resp_ptag,
  output logic              resp_dev,
  output logic              resp_l1,
  output logic              refill_req,
  output logic [VA_W-1:0]   refill_va,
  input  logic              fill_valid,
  input  logic [FLAG_W-1:0] fill_flags,
  input  logic [VA_W-1:0]   fill_offset,
  input  logic [VA_W-1:0]   fill_devbase,
  input  logic [PTAG_W-1:0] fill_ptag
);
  localparam int TAG_W = VA_W - PAGE_W;

  logic [VA_W-1:0]   cap_va;
  logic              l1_hit, l1_we, l1_any;
  logic [FLAG_W-1:0] l1_flags, sel_flags;
  logic [VA_W-1:0]   l1_offs, sel_offs;
  logic [PTAG_W-1:0] l1_ptag, sel_ptag;
  logic [WAYS-1:0]   l2_hit_vec;
  logic              l2_hit, l2_any;
  logic [WAY_W-1:0]  l2_way, l2_victim, age_way, fill_way;
  logic [FLAG_W-1:0] l2_flags;
  logic [VA_W-1:0]   l2_offs, l2_base;
  logic [PTAG_W-1:0] l2_ptag;
  logic              age_we, fill_we;
  logic [IDX_W-1:0]  cap_idx;
  logic [TAG_W-1:0]  cap_tag;

  assign cap_idx   = cap_va[PAGE_W +: IDX_W];
  assign cap_tag   = cap_va[VA_W-1:PAGE_W];
  assign refill_va = cap_va;

  xlat_l1_dm #(
    .VA_W(VA_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W), .FLAG_W(FLAG_W), .PTAG_W(PTAG_W)
  ) u_l1 (
    .clk      (clk),
    .rst      (rst),
    .inval    (inval_all),
    .rd_idx   (req_va[PAGE_W +: IDX_W]),
    .rd_tag   (req_va[VA_W-1:PAGE_W]),
    .hit      (l1_hit),
    .rd_flags (l1_flags),
    .rd_offs  (l1_offs),
    .rd_ptag  (l1_ptag),
    .wr_en    (l1_we),
    .wr_idx   (cap_idx),
    .wr_tag   (cap_tag),
    .wr_flags (sel_flags),
    .wr_offs  (sel_offs),
    .wr_ptag  (sel_ptag),
    .any_valid(l1_any)
  );

  xlat_l2_sa #(
    .VA_W(VA_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W), .FLAG_W(FLAG_W), .PTAG_W(PTAG_W)
  ) u_l2 (
    .clk       (clk),
    .rst       (rst),
    .inval     (inval_all),
    .set_idx   (cap_idx),
    .rd_tag    (cap_tag),
    .hit_vec   (l2_hit_vec),
    .hit       (l2_hit),
    .hit_way   (l2_way),
    .hit_flags (l2_flags),
    .hit_offs  (l2_offs),
    .hit_base  (l2_base),
    .hit_ptag  (l2_ptag),
    .victim    (l2_victim),
    .age_we    (age_we),
    .age_way   (age_way),
    .fill_we   (fill_we),
    .fill_way  (fill_way),
    .fill_flags(fill_flags),
    .fill_offs (fill_offset),
    .fill_base (fill_devbase),
    .fill_ptag (fill_ptag),
    .any_valid (l2_any)
  );

  xlat_ctrl #(
    .VA_W(VA_W), .FLAG_W(FLAG_W), .PTAG_W(PTAG_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inval_all (inval_all),
    .req_valid (req_valid),
    .req_va    (req_va),
    .req_ready (req_ready),
    .cap_va    (cap_va),
    .l1_hit    (l1_hit),
    .l1_flags  (l1_flags),
    .l1_offs   (l1_offs),
    .l1_ptag   (l1_ptag),
    .l1_we     (l1_we),
    .sel_flags (sel_flags),
    .sel_offs  (sel_offs),
    .sel_ptag  (sel_ptag),
    .l2_hit    (l2_hit),
    .l2_way    (l2_way),
    .l2_flags  (l2_flags),
    .l2_offs   (l2_offs),
    .l2_base   (l2_base),
    .l2_ptag   (l2_ptag),
    .l2_victim (l2_victim),
    .age_we    (age_we),
    .age_way   (age_way),
    .fill_we   (fill_we),
    .fill_way  (fill_way),
    .fill_valid(fill_valid),
    .fill_flags(fill_flags),
    .fill_offs (fill_offset),
    .fill_base (fill_devbase),
    .fill_ptag (fill_ptag),
    .resp_valid(resp_valid),
    .resp_addr (resp_addr),
    .resp_flags(resp_flags),
    .resp_ptag (resp_ptag),
    .resp_dev  (resp_dev),
    .resp_l1   (resp_l1),
    .refill_req(refill_req)
  );

endmodule

// File: rtl/xlat_tlb2_chk.sv
module xlat_tlb2_chk (
  input logic       clk,
  input logic       rst,
  input logic       inval_all,
  input logic       req_valid,
  input logic       req_ready,
  input logic       resp_valid,
  input logic       resp_dev,
  input logic       resp_l1,
  input logic       refill_req,
  input logic       fill_valid,
  input logic       l1_hit,
  input logic       l1_we,
  input logic [3:0] l2_hit_vec,
  input logic       l1_any,
  input logic       l2_any
);

  AST_L1_HIT_NEXT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && l1_hit) |=> (resp_valid && resp_l1)); // R2

  AST_L2_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
    $onehot0(l2_hit_vec)); // R3

  AST_REFILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (refill_req && !fill_valid) |=> refill_req); // R6

  AST_REFILL_BUSY: assert property (@(posedge clk) disable iff (rst)
    refill_req |-> !req_ready); // R9

  AST_MEM_PROMOTE: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_l1 && !resp_dev) |-> $past(l1_we)); // R7

  AST_DEV_NO_PROMOTE: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_dev) |-> !$past(l1_we)); // R8

  AST_INVAL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    inval_all |=> (!l1_any && !l2_any)); // R10

endmodule

bind xlat_tlb2 xlat_tlb2_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .inval_all (inval_all),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .resp_valid(resp_valid),
  .resp_dev  (resp_dev),
  .resp_l1   (resp_l1),
  .refill_req(refill_req),
  .fill_valid(fill_valid),
  .l1_hit    (l1_hit),
  .l1_we     (l1_we),
  .l2_hit_vec(l2_hit_vec),
  .l1_any    (l1_any),
  .l2_any    (l2_any)
);

// File: tb/tb_xlat_tlb2.sv
module tb_xlat_tlb2;
  localparam int CLK_P = 10;
  localparam int SETS  = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inval_all = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready;
  logic        resp_valid;
  logic [31:0] resp_addr;
  logic [3:0]  resp_flags;
  logic [19:0] resp_ptag;
  logic        resp_dev;
  logic        resp_l1;
  logic        refill_req;
  logic [31:0] refill_va;
  logic        fill_valid = 1'b0;
  logic [3:0]  fill_flags = '0;
  logic [31:0] fill_offset = '0;
  logic [31:0] fill_devbase = '0;
  logic [19:0] fill_ptag = '0;

  int n_chk  = 0;
  int n_fail = 0;

  bit         m1_v [SETS];
  logic [19:0] m1_t [SETS];
  bit         m2_v [SETS][4];
  logic [19:0] m2_t [SETS][4];
  logic [1:0] m2_a [SETS][4];

  xlat_tlb2 dut (
    .clk(clk), .rst(rst), .inval_all(inval_all),
    .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_flags(resp_flags),
    .resp_ptag(resp_ptag), .resp_dev(resp_dev), .resp_l1(resp_l1),
    .refill_req(refill_req), .refill_va(refill_va),
    .fill_valid(fill_valid), .fill_flags(fill_flags), .fill_offset(fill_offset),
    .fill_devbase(fill_devbase), .fill_ptag(fill_ptag)
  );

  always #(CLK_P/2) clk = ~clk;

  // Page description supplied by the outside walker: memory unless va[21] is set.
  function automatic bit f_mem(input logic [31:0] va);
    return !va[21];
  endfunction
  function automatic logic [3:0] f_flags(input logic [31:0] va);
    return {va[24:22], f_mem(va)};
  endfunction
  function automatic logic [31:0] f_offs(input logic [31:0] va);
    return {va[27:12] ^ 16'h5A5A, 16'h0000};
  endfunction
  function automatic logic [31:0] f_base(input logic [31:0] va);
    return {va[31:12], 12'h000} - 32'h0000_0100;
  endfunction
  function automatic logic [19:0] f_ptag(input logic [31:0] va);
    return va[31:12] ^ 20'h0F0F0;
  endfunction
  function automatic logic [31:0] f_addr(input logic [31:0] va);
    return f_mem(va) ? (f_offs(va) + va) : (va - f_base(va));
  endfunction
  function automatic logic [31:0] mk(input logic [15:0] hi, input logic [3:0] idx,
                                     input logic [11:0] lo);
    return {hi, idx, lo};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < SETS; s++) begin
      m1_v[s] = 1'b0;
      for (int w = 0; w < 4; w++) m2_v[s][w] = 1'b0;
    end
  endtask

  // Reference of R4: touched way 3, partner 2, other pair keeps bit 0.
  task automatic model_touch(input int s, input int hw);
    for (int w = 0; w < 4; w++) begin
      if (w == hw) m2_a[s][w] = 2'd3;
      else if (w == (hw ^ 1)) m2_a[s][w] = 2'd2;
      else m2_a[s][w] = m2_a[s][w] & 2'd1;
    end
  endtask

  // Reference of R5.
  function automatic int model_victim(input int s);
    int v;
    v = -1;
    for (int w = 0; w < 4; w++) if (v < 0 && !m2_v[s][w]) v = w;
    if (v < 0) begin
      v = 0;
      for (int w = 1; w < 4; w++) if (m2_a[s][w] < m2_a[s][v]) v = w;
    end
    return v;
  endfunction

  // path: 0 = first level, 1 = second level, 2 = refill
  task automatic model_access(input logic [31:0] va, output int path);
    int s;
    int hw;
    s  = int'(va[15:12]);
    hw = -1;
    if (m1_v[s] && m1_t[s] == va[31:12]) begin
      path = 0;
    end else begin
      for (int w = 0; w < 4; w++)
        if (m2_v[s][w] && m2_t[s][w] == va[31:12]) hw = w;
      if (hw < 0) begin
        path = 2;
        hw = model_victim(s);
        m2_v[s][hw] = 1'b1;
        m2_t[s][hw] = va[31:12];
      end else begin
        path = 1;
      end
      model_touch(s, hw);
      if (f_mem(va)) begin
        m1_v[s] = 1'b1;
        m1_t[s] = va[31:12];
      end
    end
  endtask

  task automatic access(input logic [31:0] va, input string req);
    int path;
    int waits;
    bit saw_refill;
    model_access(va, path);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_va    = va;
    @(negedge clk);
    req_valid = 1'b0;
    saw_refill = 1'b0;
    waits = 0;
    if (path != 0)
      check(req_ready == 1'b0, "R9", "ready while busy", 32'(req_ready), 32'd0);
    while (!resp_valid && waits < 20) begin
      if (refill_req && !saw_refill) begin
        saw_refill = 1'b1;
        check(refill_va == va, "R6", "refill_va", refill_va, va);
        fill_valid   = 1'b1;
        fill_flags   = f_flags(va);
        fill_offset  = f_offs(va);
        fill_devbase = f_base(va);
        fill_ptag    = f_ptag(va);
        @(negedge clk);
        fill_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
      waits++;
    end
    check(resp_valid == 1'b1, req, "resp_valid", 32'(resp_valid), 32'd1);
    check(resp_l1 == (path == 0), req, "resp_l1", 32'(resp_l1), 32'(path == 0));
    check(saw_refill == (path == 2), req, "refill raised", 32'(saw_refill), 32'(path == 2));
    if (path == 1)
      check(waits == 1, "R3", "second-level latency", 32'(waits), 32'd1);
    check(resp_addr == f_addr(va), req, "resp_addr", resp_addr, f_addr(va));
    check(resp_dev == !f_mem(va), f_mem(va) ? "R7" : "R8", "resp_dev",
          32'(resp_dev), 32'(!f_mem(va)));
    check({resp_flags, resp_ptag} == {f_flags(va), f_ptag(va)}, req, "flags/ptag",
          32'({resp_flags, resp_ptag}), 32'({f_flags(va), f_ptag(va)}));
  endtask

  task automatic do_inval();
    @(negedge clk);
    inval_all = 1'b1;
    @(negedge clk);
    inval_all = 1'b0;
    model_clear();
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] pa, pb, pd;
    logic [31:0] p [5];
    logic [15:0] pool [6];
    int unsigned seed_val;
    model_clear();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 4; w++) m2_a[s][w] = 2'd0;
    seed_val = $urandom(32'd20240125);

    // R1: reset state
    repeat (3) @(negedge clk);
    check(resp_valid == 1'b0, "R1", "resp_valid in reset", 32'(resp_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(resp_valid == 1'b0, "R1", "resp_valid after reset", 32'(resp_valid), 32'd0);
    check(refill_req == 1'b0, "R1", "refill_req after reset", 32'(refill_req), 32'd0);
    check(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'd1);

    // R1/R6 then R2: first touch refills, second hits first level
    pa = mk(16'h1000, 4'd1, 12'h123);
    access(pa, "R1");
    access(pa + 32'h10, "R2");

    // R3/R7: conflicting page evicts first level; original found in second level
    pb = mk(16'h2000, 4'd1, 12'h0F0);
    access(pb, "R6");
    access(pa, "R3");
    access(pa, "R7");

    // R4/R5: fill a set, refresh way 0, then a new page evicts way 2
    for (int k = 0; k < 4; k++) p[k] = mk(16'h3000 + 16'(k * 16'h0100), 4'd2, 12'h040);
    p[4] = mk(16'h3800, 4'd2, 12'h004);
    for (int k = 0; k < 4; k++) access(p[k], "R5");
    access(p[0], "R4");
    access(p[4], "R5");
    access(p[1], "R4");
    access(p[3], "R4");
    access(p[2], "R5");

    // R8: device page leaves first level alone
    pd = mk(16'h0020, 4'd1, 12'h456);
    access(pd, "R8");
    access(pd, "R8");
    access(pa, "R8");

    // R9/R10: a request during invalidate is ignored; afterwards everything refills
    @(negedge clk);
    inval_all = 1'b1;
    req_valid = 1'b1;
    req_va    = pa;
    #1;
    check(req_ready == 1'b0, "R9", "ready during invalidate", 32'(req_ready), 32'd0);
    @(negedge clk);
    inval_all = 1'b0;
    req_valid = 1'b0;
    model_clear();
    check(resp_valid == 1'b0, "R9", "ignored request response", 32'(resp_valid), 32'd0);
    @(negedge clk);
    @(negedge clk);
    check(refill_req == 1'b0, "R9", "ignored request refill", 32'(refill_req), 32'd0);
    access(pa, "R10");
    access(p[0], "R10");

    // Random mix over a small page pool
    pool[0] = 16'h0000; pool[1] = 16'h0020; pool[2] = 16'h1234;
    pool[3] = 16'h8000; pool[4] = 16'h00A0; pool[5] = 16'h4444;
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 39) == 0) begin
        do_inval();
      end else begin
        access(mk(pool[$urandom_range(0, 5)], 4'($urandom_range(0, 3)),
                  12'($urandom_range(0, 4095))), "R5");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule